// File: doc/BRIEF.md
# Set-Associative TLB Command Engine

This block holds the main translation table of a memory management unit: 128 sets of 2 or 4 ways, where each entry is a pair of 32-bit words. The first word carries the virtual page, the address space tag, a global flag and a present flag. The second word carries the frame number and the permissions. Software drives the table through four registers: an entry-tag staging register, an entry-data staging register, a slot register and a command register. Lookup, victim selection and commit are separate commands. A miss handler therefore runs probe, then get-slot, then write.

A lookup reports its result in the slot register. A single match loads the linear slot number. No match and a match in more than one way each load their own error code, and both codes have bit 31 set. The duplicate condition is found when the lookup runs, not when an entry is written. There are two write commands, and they differ only in whether they send the micro-TLB flush pulse. A separate command sends that pulse on its own.

Top module: `tlbe_cmd_engine`

## Requirements
- R1: After reset, the staging registers and the slot register read 0, `utlb_inv` is low, and every entry is invalid, so a probe returns the miss code.
- R2: Field positions in the tag word are: virtual page [31:12], present bit 10, global bit 8, tag [7:0]. The set is virtual page bits [6:0], that is tag-word bits [18:12]. A slot number is set × WAYS + way, and bit 31 is the error flag.
- R3: A probe whose key matches exactly one way of the addressed set loads that linear slot number, with bit 31 clear. The result is in the slot register after the second rising edge following the command write.
- R4: A probe that matches no way loads 32'h8000_0000.
- R5: A probe that matches two or more ways loads 32'h8000_0001.
- R6: An entry matches when it is present and its virtual page equals the key page. In addition, either its global bit is set or its 8-bit tag equals the key tag.
- R7: Get-slot loads the lowest invalid way of the set addressed by the staged tag word. If every way is present, it loads the per-set round-robin way instead, then advances that way by one modulo WAYS. The round-robin way starts at 0.
- R8: Write (opcode 3) stores both staged words at the slot register's low bits. It also drives `utlb_inv` high for exactly the one cycle after the command write.
- R9: Write-quiet (opcode 4) stores the entry the same way and leaves `utlb_inv` low.
- R10: Read (opcode 5) loads both staged registers from the entry at the slot register. Writing all-zero words makes that entry invalid, so a later probe for it misses.
- R11: Flush (opcode 6) pulses `utlb_inv` like a write does. It changes no register and no entry.
- R12: Register addresses are 0 tag word, 1 data word, 2 slot, 3 command. The opcodes are probe 1 and get-slot 2. Any other opcode has no effect. `reg_rd_data` shows the register at `reg_rd_addr` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 2 | Register address for the write |
| reg_wr_data | input | 32 | Write data; opcode in [3:0] when the command register is written |
| reg_rd_addr | input | 2 | Register address for readback |
| reg_rd_data | output | 32 | Registered readback data |
| utlb_inv | output | 1 | One-cycle micro-TLB flush pulse |

## Verification
The flush pulse is due in the cycle right after the edge that takes the command write. The bench samples it at the falling edge after that edge, and again one cycle later to confirm that it has dropped. Probe, get-slot and read results land in the registers at the second edge. Readback adds one edge. For this reason every command is followed by an idle cycle before any register is read, and each readback is sampled on the falling edge after its address is captured. The expected values come from a bench model of the table, the round-robin ways and the registers. The model is checked against directed cases (empty set, full set, global match, duplicate, erase) and against a seeded random stream confined to four sets, so that hits, conflicts and duplicates happen often.

// File: rtl/tlbe_pkg.sv
package tlbe_pkg;
  localparam int VPN_LSB    = 12;
  localparam int VPN_W      = 20;
  localparam int VALID_BIT  = 10;
  localparam int GLOBAL_BIT = 8;
  localparam int ASID_W     = 8;
  localparam int ERR_BIT    = 31;
  localparam logic [31:0] MISS_CODE = 32'h8000_0000;
  localparam logic [31:0] DUP_CODE  = 32'h8000_0001;

  localparam logic [1:0] RA_TAG  = 2'd0;
  localparam logic [1:0] RA_DATA = 2'd1;
  localparam logic [1:0] RA_SLOT = 2'd2;
  localparam logic [1:0] RA_CMD  = 2'd3;

  typedef enum logic [3:0] {
    OP_NONE    = 4'd0,
    OP_PROBE   = 4'd1,
    OP_GETSLOT = 4'd2,
    OP_WRITE   = 4'd3,
    OP_WRQUIET = 4'd4,
    OP_READ    = 4'd5,
    OP_FLUSH   = 4'd6
  } tlbe_op_e;
endpackage

// File: rtl/tlbe_way_ram.sv
module tlbe_way_ram #(
  parameter int DEPTH = 128,
  parameter int W     = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/tlbe_select.sv
module tlbe_select #(
  parameter int WAYS   = 2,
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8,
  localparam int WB    = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]             ent_vld,
  input  logic [WAYS-1:0]             ent_glb,
  input  logic [WAYS-1:0][VPN_W-1:0]  ent_vpn,
  input  logic [WAYS-1:0][ASID_W-1:0] ent_asid,
  input  logic [VPN_W-1:0]            key_vpn,
  input  logic [ASID_W-1:0]           key_asid,
  input  logic [WB-1:0]               rr_way,
  output logic                        hit_none,
  output logic                        hit_multi,
  output logic [WB-1:0]               hit_way,
  output logic                        set_full,
  output logic [WB-1:0]               pick_way
);
  logic [WAYS-1:0] hit;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit[w] = ent_vld[w] && (ent_vpn[w] == key_vpn) &&
                    (ent_glb[w] || (ent_asid[w] == key_asid));
  end

  assign hit_none  = ~|hit;
  assign hit_multi = ($countones(hit) > 1);
  assign set_full  = &ent_vld;

  always_comb begin
    hit_way  = '0;
    pick_way = rr_way;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit[w])      hit_way  = WB'(w);
      if (!ent_vld[w]) pick_way = WB'(w);
    end
  end
endmodule

// File: rtl/tlbe_cmd_engine.sv
module tlbe_cmd_engine
  import tlbe_pkg::*;
#(
  parameter int SETS = 128,
  parameter int WAYS = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr_en,
  input  logic [1:0]  reg_wr_addr,
  input  logic [31:0] reg_wr_data,
  input  logic [1:0]  reg_rd_addr,
  output logic [31:0] reg_rd_data,
  output logic        utlb_inv
);
  localparam int SB = $clog2(SETS);
  localparam int WB = $clog2(WAYS);
  localparam int IW = SB + WB;

  logic [31:0] tag_q, data_q, slot_q;

  // command decode (cycle of the command write)
  tlbe_op_e        op_in;
  logic            cmd_fire, wr_go;
  logic [SB-1:0]   key_set, slot_set, rd_set;
  logic [WB-1:0]   slot_way;

  assign op_in    = tlbe_op_e'(reg_wr_data[3:0]);
  assign cmd_fire = reg_wr_en && (reg_wr_addr == RA_CMD);
  assign wr_go    = cmd_fire && (op_in == OP_WRITE || op_in == OP_WRQUIET);
  assign key_set  = tag_q[VPN_LSB +: SB];
  assign slot_set = slot_q[WB +: SB];
  assign slot_way = slot_q[WB-1:0];
  assign rd_set   = (op_in == OP_PROBE || op_in == OP_GETSLOT) ? key_set : slot_set;

  // entry storage: one RAM per way, present bits in flops
  logic [63:0]     ram_q [WAYS];
  logic [WAYS-1:0] vld [SETS];
  logic [WB-1:0]   rr  [SETS];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    tlbe_way_ram #(.DEPTH(SETS), .W(64)) u_ram (
      .clk  (clk),
      .we   (wr_go && (slot_way == WB'(w))),
      .waddr(slot_set),
      .wdata({tag_q, data_q}),
      .raddr(rd_set),
      .rdata(ram_q[w])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) vld[s] <= '0;
    end else if (wr_go) begin
      vld[slot_set][slot_way] <= tag_q[VALID_BIT];
    end
  end

  // stage 1: results of the RAM read
  tlbe_op_e            s1_op;
  logic [SB-1:0]       s1_set;
  logic [WB-1:0]       s1_way;
  logic [WAYS-1:0]     vld_q;
  logic [WB-1:0]       rr_q;
  logic [VPN_W-1:0]    key_vpn_q;
  logic [ASID_W-1:0]   key_asid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_op      <= OP_NONE;
      s1_set     <= '0;
      s1_way     <= '0;
      vld_q      <= '0;
      rr_q       <= '0;
      key_vpn_q  <= '0;
      key_asid_q <= '0;
    end else begin
      s1_op      <= cmd_fire ? op_in : OP_NONE;
      s1_set     <= rd_set;
      s1_way     <= slot_way;
      vld_q      <= vld[rd_set];
      rr_q       <= rr[rd_set];
      key_vpn_q  <= tag_q[VPN_LSB +: VPN_W];
      key_asid_q <= tag_q[ASID_W-1:0];
    end
  end

  logic [WAYS-1:0]             ent_glb;
  logic [WAYS-1:0][VPN_W-1:0]  ent_vpn;
  logic [WAYS-1:0][ASID_W-1:0] ent_asid;

  for (genvar w = 0; w < WAYS; w++) begin : g_fld
    assign ent_glb[w]  = ram_q[w][32 + GLOBAL_BIT];
    assign ent_vpn[w]  = ram_q[w][32 + VPN_LSB +: VPN_W];
    assign ent_asid[w] = ram_q[w][32 +: ASID_W];
  end

  logic          sel_none, sel_multi, sel_full;
  logic [WB-1:0] sel_hit, sel_pick;

  tlbe_select #(.WAYS(WAYS), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_sel (
    .ent_vld  (vld_q),
    .ent_glb  (ent_glb),
    .ent_vpn  (ent_vpn),
    .ent_asid (ent_asid),
    .key_vpn  (key_vpn_q),
    .key_asid (key_asid_q),
    .rr_way   (rr_q),
    .hit_none (sel_none),
    .hit_multi(sel_multi),
    .hit_way  (sel_hit),
    .set_full (sel_full),
    .pick_way (sel_pick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) rr[s] <= '0;
    end else if (s1_op == OP_GETSLOT && sel_full) begin
      rr[s1_set] <= rr_q + 1'b1;
    end
  end

  logic [63:0] rd_ent;
  logic [31:0] vld_mask;
  assign rd_ent   = ram_q[s1_way];
  assign vld_mask = 32'(1) << VALID_BIT;

  // software writes first; command results take priority
  always_ff @(posedge clk) begin
    if (rst) begin
      tag_q  <= '0;
      data_q <= '0;
      slot_q <= '0;
    end else begin
      if (reg_wr_en && reg_wr_addr == RA_TAG)  tag_q  <= reg_wr_data;
      if (reg_wr_en && reg_wr_addr == RA_DATA) data_q <= reg_wr_data;
      if (reg_wr_en && reg_wr_addr == RA_SLOT) slot_q <= reg_wr_data;
      case (s1_op)
        OP_PROBE:
          slot_q <= sel_none  ? MISS_CODE :
                    sel_multi ? DUP_CODE  : 32'({s1_set, sel_hit});
        OP_GETSLOT:
          slot_q <= 32'({s1_set, sel_pick});
        OP_READ: begin
          tag_q  <= (rd_ent[63:32] & ~vld_mask) |
                    (vld_q[s1_way] ? vld_mask : 32'd0);
          data_q <= rd_ent[31:0];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) utlb_inv <= 1'b0;
    else     utlb_inv <= cmd_fire && (op_in == OP_WRITE || op_in == OP_FLUSH);
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rd_data <= '0;
    else begin
      case (reg_rd_addr)
        RA_TAG:  reg_rd_data <= tag_q;
        RA_DATA: reg_rd_data <= data_q;
        RA_SLOT: reg_rd_data <= slot_q;
        default: reg_rd_data <= '0;
      endcase
    end
  end

  // assertions
  p_probe_miss_r4: assert property (@(posedge clk) disable iff (rst)
    (s1_op == OP_PROBE && sel_none) |=> (slot_q == MISS_CODE));

  p_probe_dup_r5: assert property (@(posedge clk) disable iff (rst)
    (s1_op == OP_PROBE && sel_multi) |=> (slot_q == DUP_CODE));

  p_getslot_set_r7: assert property (@(posedge clk) disable iff (rst)
    (s1_op == OP_GETSLOT) |=> (!slot_q[ERR_BIT] && slot_q[IW-1:WB] == $past(s1_set)));

  p_getslot_free_r7: assert property (@(posedge clk) disable iff (rst)
    (s1_op == OP_GETSLOT && !sel_full) |-> !vld_q[sel_pick]);

  p_write_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd_fire && op_in == OP_WRITE) |=> (utlb_inv ##1 !utlb_inv));

  p_quiet_write_r9: assert property (@(posedge clk) disable iff (rst)
    (cmd_fire && op_in == OP_WRQUIET) |=> !utlb_inv);
endmodule

// File: tb/tlbe_cmd_engine_bench.sv
`timescale 1ns/1ps
module tlbe_cmd_engine_bench;
  localparam int SETS = 128;
  localparam int WAYS = 2;
  localparam int N    = SETS * WAYS;
  localparam int IW   = $clog2(N);

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wen = 1'b0;
  logic [1:0]  waddr = '0;
  logic [31:0] wdata = '0;
  logic [1:0]  raddr = '0;
  logic [31:0] rdata;
  logic        utlb_inv;

  always #2 clk = ~clk;

  tlbe_cmd_engine #(.SETS(SETS), .WAYS(WAYS)) u_tlbe_cmd_engine (
    .clk(clk), .rst(rst), .reg_wr_en(wen), .reg_wr_addr(waddr),
    .reg_wr_data(wdata), .reg_rd_addr(raddr), .reg_rd_data(rdata),
    .utlb_inv(utlb_inv)
  );

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  // model
  logic [31:0] m_tag = 0, m_data = 0, m_slot = 0;
  logic [31:0] e0 [N];
  logic [31:0] e1 [N];
  bit          ev [N];
  int          mrr [SETS];
  logic        inv_a, inv_b;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit ent_match(int i, logic [31:0] k);
    return ev[i] && (e0[i][31:12] == k[31:12]) && (e0[i][8] || e0[i][7:0] == k[7:0]);
  endfunction

  function automatic logic [31:0] m_probe(logic [31:0] k);
    int s = int'(k[18:12]);
    int cnt = 0;
    int hw = 0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (ent_match(s * WAYS + w, k)) begin cnt++; hw = w; end
    if (cnt == 0) return 32'h8000_0000;
    if (cnt > 1)  return 32'h8000_0001;
    return 32'(s * WAYS + hw);
  endfunction

  function automatic logic [31:0] m_getslot(logic [31:0] k);
    int s = int'(k[18:12]);
    for (int w = 0; w < WAYS; w++)
      if (!ev[s * WAYS + w]) return 32'(s * WAYS + w);
    begin
      int v = mrr[s];
      mrr[s] = (mrr[s] + 1) % WAYS;
      return 32'(s * WAYS + v);
    end
  endfunction

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wen = 1'b1; waddr = a; wdata = d;
    @(negedge clk); wen = 1'b0; inv_a = utlb_inv;
    if (a == 2'd0) m_tag = d;
    if (a == 2'd1) m_data = d;
    if (a == 2'd2) m_slot = d;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); raddr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic do_cmd(input logic [3:0] op, input string tag);
    int i;
    logic inv_exp;
    wr(2'd3, {28'd0, op});
    @(negedge clk); inv_b = utlb_inv;
    i = int'(m_slot[IW-1:0]);
    inv_exp = (op == 4'd3 || op == 4'd6);
    case (op)
      4'd1: m_slot = m_probe(m_tag);
      4'd2: m_slot = m_getslot(m_tag);
      4'd3, 4'd4: begin e0[i] = m_tag; e1[i] = m_data; ev[i] = m_tag[10]; end
      4'd5: begin m_tag = e0[i]; m_data = e1[i]; end
      default: ;
    endcase
    chk({tag, " R8 R9 R11 pulse"}, {31'd0, inv_a}, {31'd0, inv_exp});
    chk({tag, " R8 pulse width"}, {31'd0, inv_b}, 32'd0);
  endtask

  task automatic check_regs(input string tag);
    logic [31:0] d;
    rd(2'd0, d); chk({tag, " R12 tag reg"}, d, m_tag);
    rd(2'd1, d); chk({tag, " R12 data reg"}, d, m_data);
    rd(2'd2, d); chk({tag, " R12 slot reg"}, d, m_slot);
  endtask

  function automatic logic [31:0] mk_tag(int hi, int set, bit v, bit g, int asid);
    return {13'(hi), 7'(set), 1'b0, v, 1'b0, g, 8'(asid)};
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    for (int i = 0; i < N; i++) begin e0[i] = 0; e1[i] = 0; ev[i] = 0; end
    for (int s = 0; s < SETS; s++) mrr[s] = 0;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    chk("R1 utlb_inv", {31'd0, utlb_inv}, 32'd0);
    check_regs("R1 reset");
    wr(2'd0, mk_tag(0, 5, 1, 0, 3));
    do_cmd(4'd1, "R1 empty probe");
    rd(2'd2, d); chk("R1 R4 probe miss after reset", d, 32'h8000_0000);

    // R7/R2: empty set picks way 0 of set 5 -> slot 10
    do_cmd(4'd2, "R7 getslot");
    rd(2'd2, d); chk("R7 R2 first free slot", d, 32'd10);
    wr(2'd1, 32'h0001_2345);
    do_cmd(4'd3, "R8 write");
    chk("R8 pulse seen", {31'd0, inv_a}, 32'd1);
    do_cmd(4'd1, "R3 probe");
    rd(2'd2, d); chk("R3 single hit slot", d, 32'd10);
    do_cmd(4'd2, "R7 getslot");
    rd(2'd2, d); chk("R7 second free slot", d, 32'd11);
    wr(2'd0, mk_tag(1, 5, 1, 1, 7));
    wr(2'd1, 32'h0000_beef);
    do_cmd(4'd4, "R9 quiet write");
    chk("R9 no pulse", {31'd0, inv_a}, 32'd0);
    // R7 round robin on full set
    do_cmd(4'd2, "R7 rr");
    rd(2'd2, d); chk("R7 rr first", d, 32'd10);
    do_cmd(4'd2, "R7 rr");
    rd(2'd2, d); chk("R7 rr second", d, 32'd11);
    do_cmd(4'd2, "R7 rr");
    rd(2'd2, d); chk("R7 rr wrap", d, 32'd10);

    // R6: global entry matches other tag; non-global does not
    wr(2'd0, mk_tag(1, 5, 1, 0, 99));
    do_cmd(4'd1, "R6 global");
    rd(2'd2, d); chk("R6 global hit any tag", d, 32'd11);
    wr(2'd0, mk_tag(0, 5, 1, 0, 4));
    do_cmd(4'd1, "R6 tag mismatch");
    rd(2'd2, d); chk("R6 R4 tag mismatch misses", d, 32'h8000_0000);

    // R5: duplicate
    wr(2'd0, mk_tag(1, 5, 1, 0, 99));
    wr(2'd2, 32'd10);
    do_cmd(4'd3, "R5 dup setup");
    do_cmd(4'd1, "R5 dup probe");
    rd(2'd2, d); chk("R5 duplicate code", d, 32'h8000_0001);

    // R10: read back, then erase
    wr(2'd2, 32'd11);
    do_cmd(4'd5, "R10 read");
    check_regs("R10 read");
    wr(2'd0, 32'd0); wr(2'd1, 32'd0);
    do_cmd(4'd3, "R10 erase");
    do_cmd(4'd5, "R10 read erased");
    rd(2'd0, d); chk("R10 erased tag word", d, 32'd0);
    wr(2'd0, mk_tag(1, 5, 1, 0, 99));
    do_cmd(4'd1, "R10 probe after erase");
    rd(2'd2, d); chk("R10 single remaining hit", d, 32'd10);

    // R11 flush, R12 unknown opcode
    do_cmd(4'd6, "R11 flush");
    chk("R11 pulse seen", {31'd0, inv_a}, 32'd1);
    check_regs("R11 flush");
    do_cmd(4'd9, "R12 unknown op");
    check_regs("R12 unknown op");
    do_cmd(4'd1, "R12 entries kept");
    rd(2'd2, d); chk("R11 R12 entry intact", d, 32'd10);

    // clear the first four sets for the random phase
    wr(2'd0, 32'd0); wr(2'd1, 32'd0);
    for (int i = 0; i < 4 * WAYS; i++) begin
      wr(2'd2, 32'(i));
      do_cmd(4'd4, "init");
    end

    // constrained random stream over sets 0..3
    for (int it = 0; it < 400; it++) begin
      int r;
      logic [3:0] op;
      if ($urandom_range(0, 1) == 1)
        wr(2'd0, mk_tag($urandom_range(0, 2), $urandom_range(0, 3),
                        ($urandom_range(0, 7) != 0), ($urandom_range(0, 3) == 0),
                        $urandom_range(0, 1)));
      if ($urandom_range(0, 2) == 0) wr(2'd1, $urandom);
      if ($urandom_range(0, 2) == 0) wr(2'd2, 32'($urandom_range(0, 4 * WAYS - 1)));
      r = $urandom_range(0, 9);
      case (r)
        0, 1: op = 4'd1;
        2, 3: op = 4'd2;
        4, 5: op = 4'd3;
        6:    op = 4'd4;
        7:    op = 4'd5;
        8:    op = 4'd6;
        default: op = 4'($urandom_range(7, 15));
      endcase
      do_cmd(op, "R3 R5 R7 R10 random");
      check_regs("R3 R5 R7 R10 random");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule